// File: doc/BRIEF.md
# Command decoder with rectangular write window

This block sits behind a display controller's host port. The port delivers bytes together with a flag that marks each one as a command or as pixel data. Command bytes are decoded into a configuration register file. An opcode can take zero, one, two or thirty-two argument bytes, and a small sequencer counts the arguments as they arrive. The decoded values leave the block as plain outputs. The panel scan and the memory array read them there.

Data bytes become pixel writes. A column pointer and a row pointer walk through a programmable rectangle. They step horizontal-first or vertical-first and wrap back to the rectangle's corner. In 16-bit colour format two bytes make one pixel, high byte first. In 8-bit format every byte is a pixel. Each completed pixel gives a one-cycle write strobe with its column, row and data. Bytes that follow the gray-table opcode are passed on one at a time with an index.

Top module: `cmd_window_decoder`

## Requirements
- R1: After reset: column window 0..95 and row window 0..63. Both pointers are at 0. All three contrast registers are 0x80 and the master factor is 0xF. Remap flags are 0 and the format field is 01. Start line and offset are 0 and the multiplex register is 63. View mode is 0 and the panel is off.
- R2: Opcode 0x15 takes two arguments, the column start and then the column end (low 7 bits each). Opcode 0x75 does the same for rows (low 6 bits each). Once the second argument is taken, the matching pointer is set to the new start.
- R3: One-argument opcodes: 0x81, 0x82 and 0x83 load contrast A, B and C. 0x87 loads the master factor from bits 3:0. 0xA1 loads the start line and 0xA2 the offset, both from bits 5:0. 0xA0 loads the remap byte: bit 0 vertical stepping, bit 1 column flip, bit 4 scan flip, bit 5 split scan, bits 7:6 format.
- R4: Opcode 0xA8 loads its argument into the multiplex register only if the argument is between 15 and 63. Any other argument leaves the register unchanged.
- R5: Opcodes 0xA4..0xA7 set the view mode to the opcode's low two bits (0 normal, 1 all on, 2 all off, 3 inverse). 0xAE turns the panel off and 0xAF turns it on. 0xE3 and any opcode not listed change nothing and take no arguments.
- R6: Opcode 0xB8 takes 32 arguments. Each one gives a one-cycle table strobe on the next cycle, with index 0..31 in arrival order and the byte itself.
- R7: A format field other than 00 selects 16-bit pixels: the first data byte is held as the high byte and the second completes the pixel. Format 00 makes each data byte a pixel {0x00, byte}.
- R8: In horizontal stepping the column advances after each pixel. At the column end it returns to the column start and the row advances. At the row end the row returns to the row start.
- R9: In vertical stepping (remap bit 0 = 1) the row and column roles of R8 are swapped.
- R10: A data byte that arrives while arguments are outstanding cancels the pending command. A half-received column or row command changes nothing. The data byte is then treated as pixel data.
- R11: A command byte discards a held high byte, so the next data byte starts a new pixel.
- R12: A pixel write is presented one cycle after its completing byte, at the pointer position before the step. The pointers move only when a pixel completes or R2 reloads them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | A byte is presented this cycle |
| in_is_data | input | 1 | 1 = pixel data, 0 = command or argument |
| in_byte | input | 8 | Byte value |
| win_col_lo | output | 7 | Column window start |
| win_col_hi | output | 7 | Column window end |
| win_row_lo | output | 6 | Row window start |
| win_row_hi | output | 6 | Row window end |
| gain_a | output | 8 | Contrast, colour A |
| gain_b | output | 8 | Contrast, colour B |
| gain_c | output | 8 | Contrast, colour C |
| gain_master | output | 4 | Master current factor |
| addr_vert | output | 1 | Vertical stepping selected |
| col_flip | output | 1 | Column reversal |
| scan_flip | output | 1 | Scan direction reversal |
| scan_split | output | 1 | Odd/even scan split |
| pix_fmt | output | 2 | Colour format field |
| first_line | output | 6 | Display start line |
| line_shift | output | 6 | Display offset |
| mux_lines | output | 6 | Multiplex register (rows minus one) |
| view_mode | output | 2 | Display mode |
| panel_on | output | 1 | Panel enabled |
| tbl_we | output | 1 | Gray-table byte strobe |
| tbl_idx | output | 5 | Gray-table entry index |
| tbl_byte | output | 8 | Gray-table entry value |
| pix_we | output | 1 | Pixel write strobe |
| pix_col | output | 7 | Pixel column |
| pix_row | output | 6 | Pixel row |
| pix_data | output | 16 | Pixel value |

## Verification
The assertions check these properties on every cycle:
- the column pointer reloads after a completed column command;
- the multiplex register never drops below its floor;
- the argument counter clears on any data byte;
- pixel and table strobes appear only one cycle after a matching input byte;
- the pointers hold still on idle cycles.

Only the bench scenarios can show the following:
- the wrap order of the pointers in both stepping modes;
- high-then-low pixel assembly;
- cancellation of half-received commands and of held high bytes;
- the index order of table bytes.

The bench shows these by comparing every output with a behavioural model on each clock.

// File: rtl/cmd_window_decoder.sv
module cmd_window_decoder #(
  parameter int COLS    = 96,
  parameter int ROWS    = 64,
  parameter int GS_LEN  = 32,
  parameter int MUX_MIN = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_vld,
  input  logic                       in_is_data,
  input  logic [7:0]                 in_byte,
  output logic [$clog2(COLS)-1:0]    win_col_lo,
  output logic [$clog2(COLS)-1:0]    win_col_hi,
  output logic [$clog2(ROWS)-1:0]    win_row_lo,
  output logic [$clog2(ROWS)-1:0]    win_row_hi,
  output logic [7:0]                 gain_a,
  output logic [7:0]                 gain_b,
  output logic [7:0]                 gain_c,
  output logic [3:0]                 gain_master,
  output logic                       addr_vert,
  output logic                       col_flip,
  output logic                       scan_flip,
  output logic                       scan_split,
  output logic [1:0]                 pix_fmt,
  output logic [$clog2(ROWS)-1:0]    first_line,
  output logic [$clog2(ROWS)-1:0]    line_shift,
  output logic [$clog2(ROWS)-1:0]    mux_lines,
  output logic [1:0]                 view_mode,
  output logic                       panel_on,
  output logic                       tbl_we,
  output logic [$clog2(GS_LEN)-1:0]  tbl_idx,
  output logic [7:0]                 tbl_byte,
  output logic                       pix_we,
  output logic [$clog2(COLS)-1:0]    pix_col,
  output logic [$clog2(ROWS)-1:0]    pix_row,
  output logic [15:0]                pix_data
);
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);
  localparam int GW = $clog2(GS_LEN);
  localparam int LW = $clog2(GS_LEN + 1);
  localparam logic [CW-1:0] COL_LAST  = CW'(COLS - 1);
  localparam logic [RW-1:0] ROW_LAST  = RW'(ROWS - 1);
  localparam logic [7:0]    MUX_LO    = 8'(MUX_MIN);
  localparam logic [7:0]    MUX_HI    = 8'(ROWS - 1);
  localparam logic [RW-1:0] MUX_FLOOR = RW'(MUX_MIN);

  logic [7:0]    op_q;
  logic [LW-1:0] left_q;
  logic [GW-1:0] idx_q;
  logic [CW-1:0] hold_q;
  logic [7:0]    hi_q;
  logic          hi_vld;
  logic [CW-1:0] col_q, col_nx;
  logic [RW-1:0] row_q, row_nx;

  function automatic logic [LW-1:0] arg_count(input logic [7:0] op);
    case (op)
      8'h15, 8'h75: return LW'(2);
      8'h81, 8'h82, 8'h83, 8'h87,
      8'hA0, 8'hA1, 8'hA2, 8'hA8: return LW'(1);
      8'hB8: return LW'(GS_LEN);
      default: return '0;
    endcase
  endfunction

  wire col_end = (col_q == win_col_hi);
  wire row_end = (row_q == win_row_hi);

  always_comb begin
    col_nx = col_q;
    row_nx = row_q;
    if (!addr_vert) begin
      col_nx = col_end ? win_col_lo : col_q + 1'b1;
      if (col_end) row_nx = row_end ? win_row_lo : row_q + 1'b1;
    end else begin
      row_nx = row_end ? win_row_lo : row_q + 1'b1;
      if (row_end) col_nx = col_end ? win_col_lo : col_q + 1'b1;
    end
  end

  wire byte8   = (pix_fmt == 2'b00);
  wire pix_done = in_vld && in_is_data && (byte8 || hi_vld);
  wire mux_ok  = (in_byte >= MUX_LO) && (in_byte <= MUX_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0; left_q <= '0; idx_q <= '0; hold_q <= '0;
      hi_q <= '0; hi_vld <= 1'b0;
      col_q <= '0; row_q <= '0;
      win_col_lo <= '0; win_col_hi <= COL_LAST;
      win_row_lo <= '0; win_row_hi <= ROW_LAST;
      gain_a <= 8'h80; gain_b <= 8'h80; gain_c <= 8'h80; gain_master <= 4'hF;
      addr_vert <= 1'b0; col_flip <= 1'b0; scan_flip <= 1'b0; scan_split <= 1'b0;
      pix_fmt <= 2'b01;
      first_line <= '0; line_shift <= '0; mux_lines <= ROW_LAST;
      view_mode <= 2'd0; panel_on <= 1'b0;
      tbl_we <= 1'b0; tbl_idx <= '0; tbl_byte <= '0;
      pix_we <= 1'b0; pix_col <= '0; pix_row <= '0; pix_data <= '0;
    end else begin
      pix_we <= 1'b0;
      tbl_we <= 1'b0;
      if (in_vld && in_is_data) begin
        left_q <= '0;
        if (pix_done) begin
          pix_we   <= 1'b1;
          pix_col  <= col_q;
          pix_row  <= row_q;
          pix_data <= byte8 ? {8'h00, in_byte} : {hi_q, in_byte};
          col_q    <= col_nx;
          row_q    <= row_nx;
          hi_vld   <= 1'b0;
        end else begin
          hi_q   <= in_byte;
          hi_vld <= 1'b1;
        end
      end else if (in_vld) begin
        hi_vld <= 1'b0;
        if (left_q == '0) begin
          op_q   <= in_byte;
          left_q <= arg_count(in_byte);
          idx_q  <= '0;
          if (in_byte[7:2] == 6'b101001) view_mode <= in_byte[1:0];
          if (in_byte[7:1] == 7'b1010111) panel_on <= in_byte[0];
        end else begin
          left_q <= left_q - 1'b1;
          idx_q  <= idx_q + 1'b1;
          case (op_q)
            8'h15: if (idx_q == '0) hold_q <= in_byte[CW-1:0];
                   else begin
                     win_col_lo <= hold_q;
                     win_col_hi <= in_byte[CW-1:0];
                     col_q      <= hold_q;
                   end
            8'h75: if (idx_q == '0) hold_q <= CW'(in_byte[RW-1:0]);
                   else begin
                     win_row_lo <= hold_q[RW-1:0];
                     win_row_hi <= in_byte[RW-1:0];
                     row_q      <= hold_q[RW-1:0];
                   end
            8'h81: gain_a <= in_byte;
            8'h82: gain_b <= in_byte;
            8'h83: gain_c <= in_byte;
            8'h87: gain_master <= in_byte[3:0];
            8'hA0: begin
              addr_vert  <= in_byte[0];
              col_flip   <= in_byte[1];
              scan_flip  <= in_byte[4];
              scan_split <= in_byte[5];
              pix_fmt    <= in_byte[7:6];
            end
            8'hA1: first_line <= in_byte[RW-1:0];
            8'hA2: line_shift <= in_byte[RW-1:0];
            8'hA8: if (mux_ok) mux_lines <= in_byte[RW-1:0];
            8'hB8: begin
              tbl_we   <= 1'b1;
              tbl_idx  <= idx_q;
              tbl_byte <= in_byte;
            end
            default: ;
          endcase
        end
      end
    end
  end

  p_col_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_is_data && left_q == LW'(1) && op_q == 8'h15) |=> (col_q == win_col_lo));

  p_mux_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mux_lines >= MUX_FLOOR);

  p_data_aborts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_is_data) |=> (left_q == '0));

  p_pix_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    pix_we |-> $past(in_vld && in_is_data));

  p_ptr_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(col_q) && $stable(row_q)));

  p_tbl_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> $past(in_vld && !in_is_data && op_q == 8'hB8 && left_q != '0));
endmodule

// File: tb/test_cmd_window_decoder.sv
`timescale 1ns/1ps
module test_cmd_window_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0, in_is_data = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic [6:0] win_col_lo, win_col_hi, pix_col;
  logic [5:0] win_row_lo, win_row_hi, first_line, line_shift, mux_lines, pix_row;
  logic [7:0] gain_a, gain_b, gain_c, tbl_byte;
  logic [3:0] gain_master;
  logic addr_vert, col_flip, scan_flip, scan_split, panel_on, tbl_we, pix_we;
  logic [1:0] pix_fmt, view_mode;
  logic [4:0] tbl_idx;
  logic [15:0] pix_data;
  int checks = 0, failures = 0;
  bit started = 0, done = 0;

  always #4 clk = ~clk;

  cmd_window_decoder i_cmd_window_decoder (.*);

  int m_cl, m_ch, m_rl, m_rh, m_col, m_row, m_ga, m_gb, m_gc, m_gm;
  int m_remap, m_fl, m_ls, m_mux, m_mode, m_on;
  int m_op, m_need, m_hi, m_hiv;
  int m_pwe, m_pcol, m_prow, m_pdata, m_twe, m_tidx, m_tbyte;
  logic [7:0] argq[$];

  task automatic m_reset();
    m_cl = 0; m_ch = 95; m_rl = 0; m_rh = 63; m_col = 0; m_row = 0;
    m_ga = 128; m_gb = 128; m_gc = 128; m_gm = 15; m_remap = 8'h40;
    m_fl = 0; m_ls = 0; m_mux = 63; m_mode = 0; m_on = 0;
    m_op = 0; m_need = 0; m_hi = 0; m_hiv = 0; argq.delete();
    m_pwe = 0; m_pcol = 0; m_prow = 0; m_pdata = 0; m_twe = 0; m_tidx = 0; m_tbyte = 0;
  endtask

  function automatic int needs(int op);
    if (op == 'h15 || op == 'h75) return 2;
    if (op inside {'h81, 'h82, 'h83, 'h87, 'hA0, 'hA1, 'hA2, 'hA8}) return 1;
    if (op == 'hB8) return 32;
    return 0;
  endfunction

  task automatic m_step();
    bit ce = (m_col == m_ch), re = (m_row == m_rh);
    if (m_remap[0] == 0) begin
      m_col = ce ? m_cl : (m_col + 1) % 128;
      if (ce) m_row = re ? m_rl : (m_row + 1) % 64;
    end else begin
      m_row = re ? m_rl : (m_row + 1) % 64;
      if (re) m_col = ce ? m_cl : (m_col + 1) % 128;
    end
  endtask

  always @(posedge clk) begin
    m_pwe = 0; m_twe = 0;
    if (!rst_n) m_reset();
    else if (in_vld && in_is_data) begin
      m_need = 0; argq.delete();
      if (m_remap[7:6] == 0 || m_hiv) begin
        m_pwe = 1; m_pcol = m_col; m_prow = m_row;
        m_pdata = (m_remap[7:6] == 0) ? in_byte : (m_hi * 256 + in_byte);
        m_hiv = 0; m_step();
      end else begin m_hi = in_byte; m_hiv = 1; end
    end else if (in_vld) begin
      m_hiv = 0;
      if (m_need == 0) begin
        m_op = in_byte; m_need = needs(in_byte); argq.delete();
        if (in_byte >= 'hA4 && in_byte <= 'hA7) m_mode = in_byte - 'hA4;
        if (in_byte == 'hAE) m_on = 0;
        if (in_byte == 'hAF) m_on = 1;
      end else begin
        argq.push_back(in_byte);
        if (m_op == 'hB8) begin m_twe = 1; m_tidx = argq.size() - 1; m_tbyte = in_byte; end
        if (argq.size() == m_need) begin
          case (m_op)
            'h15: begin m_cl = argq[0] % 128; m_ch = argq[1] % 128; m_col = m_cl; end
            'h75: begin m_rl = argq[0] % 64; m_rh = argq[1] % 64; m_row = m_rl; end
            'h81: m_ga = argq[0];
            'h82: m_gb = argq[0];
            'h83: m_gc = argq[0];
            'h87: m_gm = argq[0] % 16;
            'hA0: m_remap = argq[0];
            'hA1: m_fl = argq[0] % 64;
            'hA2: m_ls = argq[0] % 64;
            'hA8: if (argq[0] >= 15 && argq[0] <= 63) m_mux = argq[0];
            default: ;
          endcase
          m_need = 0;
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    chk("R2 col window", {win_col_lo, win_col_hi}, m_cl * 128 + m_ch);
    chk("R2 row window", {win_row_lo, win_row_hi}, m_rl * 64 + m_rh);
    chk("R3 contrast", {gain_a, gain_b, gain_c, gain_master}, ((m_ga * 256 + m_gb) * 256 + m_gc) * 16 + m_gm);
    chk("R3 remap", {pix_fmt, scan_split, scan_flip, col_flip, addr_vert},
        (m_remap[7:6] << 4) | (m_remap[5] << 3) | (m_remap[4] << 2) | (m_remap[1] << 1) | m_remap[0]);
    chk("R3 lines", {first_line, line_shift}, m_fl * 64 + m_ls);
    chk("R4 mux", mux_lines, m_mux);
    chk("R5 mode", {view_mode, panel_on}, m_mode * 2 + m_on);
    chk("R6 table strobe", tbl_we, m_twe);
    if (m_twe) chk("R6 table entry", {tbl_idx, tbl_byte}, m_tidx * 256 + m_tbyte);
    chk("R12 pixel strobe", pix_we, m_pwe);
    if (m_pwe) begin
      chk("R8 pixel position", {pix_col, pix_row}, m_pcol * 64 + m_prow);
      chk("R7 pixel data", pix_data, m_pdata);
    end
  end

  task automatic send(bit d, logic [7:0] b);
    @(negedge clk); in_vld = 1'b1; in_is_data = d; in_byte = b;
    @(negedge clk); in_vld = 1'b0;
  endtask

  task automatic burst(int n, int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_vld = 1'b1; in_is_data = 1'b1; in_byte = 8'(base + i);
    end
    @(negedge clk); in_vld = 1'b0;
  endtask

  initial begin
    #(8ns * 200000);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1; started = 1;
    chk("R1 reset window", {win_col_lo, win_col_hi, win_row_lo, win_row_hi}, {7'd0, 7'd95, 6'd0, 6'd63});
    chk("R1 reset gains", {gain_a, gain_b, gain_c, gain_master}, 28'h808080F);
    chk("R1 reset misc", {pix_fmt, addr_vert, first_line, mux_lines, view_mode, panel_on}, {2'b01, 1'b0, 6'd0, 6'd63, 2'd0, 1'b0});
    // R2, R8: window 2..4 x 1..2, horizontal 16-bit
    send(0, 8'h15); send(0, 8'd2); send(0, 8'd4);
    send(0, 8'h75); send(0, 8'd1); send(0, 8'd2);
    send(1, 8'h12); send(1, 8'h34);
    chk("R7 first pixel data", pix_data, 16'h1234);
    chk("R2 first pixel position", {pix_col, pix_row}, {7'd2, 6'd1});
    burst(10, 8'h40);
    send(1, 8'hAB); send(1, 8'hCD);
    chk("R8 wrap to window corner", {pix_col, pix_row, pix_data}, {7'd2, 6'd1, 16'hABCD});
    // R9: vertical stepping
    send(0, 8'hA0); send(0, 8'h41);
    send(0, 8'h15); send(0, 8'd2); send(0, 8'd4);
    send(0, 8'h75); send(0, 8'd1); send(0, 8'd2);
    burst(4, 8'h10);
    send(1, 8'h55); send(1, 8'h66);
    chk("R9 vertical third pixel", {pix_col, pix_row}, {7'd3, 6'd1});
    burst(12, 8'h20);
    // R7: 8-bit format
    send(0, 8'hA0); send(0, 8'h00);
    send(1, 8'h5A);
    chk("R7 byte pixel", pix_data, 16'h005A);
    burst(7, 8'h70);
    // R3
    send(0, 8'h81); send(0, 8'h11); send(0, 8'h82); send(0, 8'h22);
    send(0, 8'h83); send(0, 8'h33); send(0, 8'h87); send(0, 8'hF5);
    send(0, 8'hA1); send(0, 8'h7F); send(0, 8'hA2); send(0, 8'h05);
    send(0, 8'hA0); send(0, 8'hF3);
    chk("R3 gains loaded", {gain_a, gain_b, gain_c, gain_master}, 28'h1122335);
    chk("R3 remap fields", {pix_fmt, scan_split, scan_flip, col_flip, addr_vert, first_line, line_shift},
        {2'b11, 4'b1111, 6'd63, 6'd5});
    send(0, 8'hA0); send(0, 8'h40);
    // R4
    send(0, 8'hA8); send(0, 8'd10);
    chk("R4 low argument ignored", mux_lines, 6'd63);
    send(0, 8'hA8); send(0, 8'd20);
    chk("R4 argument taken", mux_lines, 6'd20);
    send(0, 8'hA8); send(0, 8'd64);
    chk("R4 high argument ignored", mux_lines, 6'd20);
    // R5
    send(0, 8'hA5); send(0, 8'hA7); send(0, 8'hAF); send(0, 8'hE3); send(0, 8'h00);
    chk("R5 mode and power", {view_mode, panel_on}, {2'd3, 1'b1});
    send(0, 8'hA4); send(0, 8'hAE);
    chk("R5 normal and off", {view_mode, panel_on}, {2'd0, 1'b0});
    // R6
    send(0, 8'hB8);
    for (int i = 0; i < 32; i++) send(0, 8'(i * 3 + 1));
    chk("R6 last table entry", {tbl_idx, tbl_byte}, {5'd31, 8'd94});
    send(0, 8'hE3);
    // R10
    send(0, 8'h15); send(0, 8'h05); send(1, 8'h77); send(1, 8'h88);
    chk("R10 aborted data forms pixel", pix_data, 16'h7788);
    send(0, 8'hE3);
    chk("R10 window unchanged", {win_col_lo, win_col_hi}, {7'd2, 7'd4});
    send(0, 8'h81); send(1, 8'h99); send(0, 8'h81); send(0, 8'h44);
    chk("R10 contrast after abort", gain_a, 8'h44);
    // R11
    send(0, 8'h15); send(0, 8'd0); send(0, 8'd95);
    send(0, 8'h75); send(0, 8'd0); send(0, 8'd63);
    send(1, 8'hAA); send(0, 8'hE3); send(1, 8'h11); send(1, 8'h22);
    chk("R11 held byte dropped", {pix_col, pix_row, pix_data}, {7'd0, 6'd0, 16'h1122});
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule